// File: doc/BRIEF.md
# Shadow Pixel Counter

This block sits on the digitized video stream of a linear image sensor that measures the width of an object's shadow. It follows one line of the sensor at a time, keeps only the photosites that carry real image data, cleans each of them with a three-sample median, and sorts them into a bright (lit) count and a dark (shadowed) count. The host takes the dark count as the number of covered photosites and converts it into a physical width.

A line begins with a one-cycle `line_start_i` pulse. After that, every cycle with `pix_valid_i` high carries one sensor output, counted from index 0. Each line has 5076 outputs: 61 leading outputs that are dummies or dark references, 5000 image photosites at indices 61 to 5060, and 15 trailing outputs. Any outputs after the 5076th are idle clocks and are dropped.

The decision threshold and the plausibility ceiling are captured when the line starts. When the last image photosite has been classified, the two counts are final and a one-cycle strobe marks them.

Top module: `shadow_pixel_counter`

## Requirements
- R1: Only valid pixels at indices 61 to 5060 are counted. Index 0 is the first valid pixel after `line_start_i`. Pixels at other indices, pixels after index 5075, and pixels received before any line start have no effect on either count.
- R2: A processed value strictly greater than the sampled threshold adds one to the bright count. A value equal to or below the threshold adds one to the dark count.
- R3: Image photosites 1 to 4998 of a line (numbered 0 to 4999) are replaced by the median of themselves and their immediate valid neighbours in the same line. Photosites 0 and 4999 keep their raw value, so an isolated spike is suppressed except at the two ends.
- R4: A photosite whose overflow flag is 1 is counted as bright, whatever its data value, its neighbours or the ceiling.
- R5: A photosite whose processed value is strictly greater than the sampled ceiling, and whose overflow flag is 0, is added to neither count.
- R6: Both counts are 13 bits wide. Both read 0 after reset and are cleared by `line_start_i`. Their sum never exceeds 5000.
- R7: `result_valid_o` is high for exactly one cycle per completed line, after the last image photosite has been counted. The counts then hold until the next `line_start_i`.
- R8: `thresh_i` and `ceil_i` are sampled in the `line_start_i` cycle. Changing them during a line has no effect on that line.
- R9: A pixel presented in the same cycle as `line_start_i` is ignored. A `line_start_i` in the middle of a line discards that line, so it produces no strobe and leaves no contribution in the counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | One-cycle pulse that begins a line and samples the threshold and ceiling |
| pix_valid_i | input | 1 | Qualifies `pix_data_i` and `pix_ovf_i` |
| pix_data_i | input | 14 | Converter sample |
| pix_ovf_i | input | 1 | Converter over-range flag |
| thresh_i | input | 14 | Bright/dark decision threshold |
| ceil_i | input | 14 | Plausibility ceiling; processed values above it are rejected |
| bright_cnt_o | output | 13 | Count of bright photosites |
| dark_cnt_o | output | 13 | Count of dark photosites |
| result_valid_o | output | 1 | One-cycle strobe that marks final counts |

## Verification
If the index counter is off by even one position, an ordinary line moves one output into the image window. The bench surrounds the window with over-range, full-scale outputs, so this shows up as a wrong bright count on the next strobe. A median pipeline that loses its previous or current sample either lets isolated spikes through or damages the two end photosites, and the spike patterns then change the counts of that same line. Threshold or ceiling registers that track their inputs during a line show up in the counts only on the line in which the input changed. A strobe that repeats, or that fires on a discarded line, is caught by counting strobes per line.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

  localparam int unsigned PIX_W = 14;

  typedef logic [PIX_W-1:0] pix_val_t;

  typedef struct packed {
    logic     ovf;
    pix_val_t val;
  } pix_t;

  function automatic pix_val_t med3(pix_val_t a, pix_val_t b, pix_val_t c);
    pix_val_t lo;
    pix_val_t hi;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    return (c < lo) ? lo : ((c > hi) ? hi : c);
  endfunction

endpackage

// File: rtl/line_window.sv
module line_window
  import shadow_pkg::*;
#(
  parameter int unsigned LINE_LEN = 5076,
  parameter int unsigned LEAD     = 61,
  parameter int unsigned ACTIVE   = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic pix_valid_i,
  input  pix_t pix_i,
  output logic e_valid_o,
  output pix_t e_pix_o,
  output logic e_first_o,
  output logic e_last_o
);

  localparam int unsigned IDX_W = $clog2(LINE_LEN + 1);
  localparam logic [IDX_W-1:0] END_IDX   = IDX_W'(LINE_LEN);
  localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(LEAD);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(LEAD + ACTIVE - 1);

  logic [IDX_W-1:0] idx_q;
  logic             e_valid_q, e_first_q, e_last_q;
  pix_t             e_pix_q;
  logic             in_line, in_win;

  assign in_line = idx_q < END_IDX;
  assign in_win  = (idx_q >= FIRST_IDX) && (idx_q <= LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= END_IDX;
      e_valid_q <= 1'b0;
      e_first_q <= 1'b0;
      e_last_q  <= 1'b0;
      e_pix_q   <= '0;
    end else if (clear_i) begin
      idx_q     <= '0;
      e_valid_q <= 1'b0;
      e_first_q <= 1'b0;
      e_last_q  <= 1'b0;
    end else begin
      e_valid_q <= 1'b0;
      e_first_q <= 1'b0;
      e_last_q  <= 1'b0;
      if (pix_valid_i && in_line) begin
        idx_q <= idx_q + 1'b1;
        if (in_win) begin
          e_valid_q <= 1'b1;
          e_pix_q   <= pix_i;
          e_first_q <= (idx_q == FIRST_IDX);
          e_last_q  <= (idx_q == LAST_IDX);
        end
      end
    end
  end

  assign e_valid_o = e_valid_q;
  assign e_pix_o   = e_pix_q;
  assign e_first_o = e_first_q;
  assign e_last_o  = e_last_q;

  a_r1_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= END_IDX);

  a_r1_nothing_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    e_last_q |=> !e_valid_q);

endmodule

// File: rtl/spike_median.sv
module spike_median
  import shadow_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic in_valid_i,
  input  pix_t in_pix_i,
  input  logic in_first_i,
  input  logic in_last_i,
  output logic o_valid_o,
  output pix_t o_pix_o,
  output logic o_last_o
);

  pix_t prev_q, cur_q, o_pix_q;
  logic have_q, cur_first_q, flush_q, o_valid_q, o_last_q;

  // the output lags by one sample; the last sample leaves on a flush cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q      <= '0;
      cur_q       <= '0;
      o_pix_q     <= '0;
      have_q      <= 1'b0;
      cur_first_q <= 1'b0;
      flush_q     <= 1'b0;
      o_valid_q   <= 1'b0;
      o_last_q    <= 1'b0;
    end else if (clear_i) begin
      have_q      <= 1'b0;
      cur_first_q <= 1'b0;
      flush_q     <= 1'b0;
      o_valid_q   <= 1'b0;
      o_last_q    <= 1'b0;
    end else begin
      o_valid_q <= 1'b0;
      o_last_q  <= 1'b0;
      if (flush_q) begin
        o_valid_q <= 1'b1;
        o_last_q  <= 1'b1;
        o_pix_q   <= cur_q;
        flush_q   <= 1'b0;
        have_q    <= 1'b0;
      end else if (in_valid_i) begin
        if (in_first_i) begin
          cur_q       <= in_pix_i;
          cur_first_q <= 1'b1;
          have_q      <= 1'b1;
          flush_q     <= in_last_i;
        end else if (have_q) begin
          o_valid_q   <= 1'b1;
          o_pix_q.ovf <= cur_q.ovf;
          o_pix_q.val <= cur_first_q ? cur_q.val
                                     : med3(prev_q.val, cur_q.val, in_pix_i.val);
          prev_q      <= cur_q;
          cur_q       <= in_pix_i;
          cur_first_q <= 1'b0;
          flush_q     <= in_last_i;
        end
      end
    end
  end

  assign o_valid_o = o_valid_q;
  assign o_pix_o   = o_pix_q;
  assign o_last_o  = o_last_q;

  a_r3_no_input_on_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_q |-> !in_valid_i);

  a_r3_last_emitted: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    (in_valid_i && in_last_i) |=> ##1 (o_valid_q && o_last_q));

endmodule

// File: rtl/pixel_classifier.sv
module pixel_classifier
  import shadow_pkg::*;
#(
  parameter int unsigned ACTIVE = 5000,
  parameter int unsigned CNT_W  = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  pix_val_t         thresh_i,
  input  pix_val_t         ceil_i,
  input  logic             in_valid_i,
  input  pix_t             in_pix_i,
  input  logic             in_last_i,
  output logic [CNT_W-1:0] bright_o,
  output logic [CNT_W-1:0] dark_o,
  output logic             done_o
);

  localparam logic [CNT_W:0] MAX_SUM = (CNT_W + 1)'(ACTIVE);

  pix_val_t         thr_q, ceil_q;
  logic [CNT_W-1:0] bright_q, dark_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q    <= '0;
      ceil_q   <= '0;
      bright_q <= '0;
      dark_q   <= '0;
      done_q   <= 1'b0;
    end else if (clear_i) begin
      thr_q    <= thresh_i;
      ceil_q   <= ceil_i;
      bright_q <= '0;
      dark_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= in_valid_i && in_last_i;
      if (in_valid_i) begin
        // overflow wins over the ceiling check
        if (in_pix_i.ovf)                 bright_q <= bright_q + 1'b1;
        else if (in_pix_i.val > ceil_q)   ;
        else if (in_pix_i.val > thr_q)    bright_q <= bright_q + 1'b1;
        else                              dark_q   <= dark_q + 1'b1;
      end
    end
  end

  assign bright_o = bright_q;
  assign dark_o   = dark_q;
  assign done_o   = done_q;

  a_r6_sum_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, bright_q} + {1'b0, dark_q}) <= MAX_SUM);

  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (bright_q == '0 && dark_q == '0));

  a_r7_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !clear_i) |=> ($stable(bright_q) && $stable(dark_q)));

  a_r8_sampled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> ($stable(thr_q) && $stable(ceil_q)));

  a_r4_ovf_bright: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_pix_i.ovf && !clear_i) |=>
      (bright_q == $past(bright_q) + 1'b1 && $stable(dark_q)));

endmodule

// File: rtl/shadow_pixel_counter.sv
module shadow_pixel_counter
  import shadow_pkg::*;
#(
  parameter int unsigned LINE_LEN = 5076,
  parameter int unsigned LEAD     = 61,
  parameter int unsigned ACTIVE   = 5000,
  parameter int unsigned CNT_W    = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_start_i,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_data_i,
  input  logic             pix_ovf_i,
  input  logic [PIX_W-1:0] thresh_i,
  input  logic [PIX_W-1:0] ceil_i,
  output logic [CNT_W-1:0] bright_cnt_o,
  output logic [CNT_W-1:0] dark_cnt_o,
  output logic             result_valid_o
);

  pix_t raw_pix, e_pix, f_pix;
  logic e_valid, e_first, e_last;
  logic f_valid, f_last;

  assign raw_pix.ovf = pix_ovf_i;
  assign raw_pix.val = pix_data_i;

  line_window #(
    .LINE_LEN(LINE_LEN),
    .LEAD    (LEAD),
    .ACTIVE  (ACTIVE)
  ) i_window (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (line_start_i),
    .pix_valid_i(pix_valid_i),
    .pix_i      (raw_pix),
    .e_valid_o  (e_valid),
    .e_pix_o    (e_pix),
    .e_first_o  (e_first),
    .e_last_o   (e_last)
  );

  spike_median i_median (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (line_start_i),
    .in_valid_i(e_valid),
    .in_pix_i  (e_pix),
    .in_first_i(e_first),
    .in_last_i (e_last),
    .o_valid_o (f_valid),
    .o_pix_o   (f_pix),
    .o_last_o  (f_last)
  );

  pixel_classifier #(
    .ACTIVE(ACTIVE),
    .CNT_W (CNT_W)
  ) i_classifier (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (line_start_i),
    .thresh_i  (thresh_i),
    .ceil_i    (ceil_i),
    .in_valid_i(f_valid),
    .in_pix_i  (f_pix),
    .in_last_i (f_last),
    .bright_o  (bright_cnt_o),
    .dark_o    (dark_cnt_o),
    .done_o    (result_valid_o)
  );

endmodule

// File: tb/test_shadow_pixel_counter.sv
`timescale 1ns/1ps
module test_shadow_pixel_counter;

  localparam int LINE_LEN = 5076;
  localparam int LEAD     = 61;
  localparam int ACTIVE   = 5000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        line_start_i = 1'b0;
  logic        pix_valid_i = 1'b0;
  logic [13:0] pix_data_i = '0;
  logic        pix_ovf_i = 1'b0;
  logic [13:0] thresh_i = '0;
  logic [13:0] ceil_i = '0;
  logic [12:0] bright_cnt_o, dark_cnt_o;
  logic        result_valid_o;

  always #4 clk = ~clk;

  shadow_pixel_counter i_shadow_pixel_counter (
    .clk_i(clk), .rst_ni(rst_ni), .line_start_i(line_start_i),
    .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i), .pix_ovf_i(pix_ovf_i),
    .thresh_i(thresh_i), .ceil_i(ceil_i),
    .bright_cnt_o(bright_cnt_o), .dark_cnt_o(dark_cnt_o),
    .result_valid_o(result_valid_o)
  );

  int checks = 0, fails = 0;
  int pulses = 0, wide = 0, cap_b = 0, cap_d = 0;
  logic prev_v = 1'b0;
  int exp_b, exp_d;
  logic [13:0] ld [LINE_LEN];
  bit          lo [LINE_LEN];

  always @(negedge clk) begin
    if (result_valid_o) begin
      pulses++;
      cap_b = bright_cnt_o;
      cap_d = dark_cnt_o;
      if (prev_v) wide++;
    end
    prev_v = result_valid_o;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int mid3(int a, int b, int c);
    if ((a >= b && a <= c) || (a <= b && a >= c)) return a;
    if ((b >= a && b <= c) || (b <= a && b >= c)) return b;
    return c;
  endfunction

  function automatic void model(int thr, int mx);
    exp_b = 0; exp_d = 0;
    for (int k = 0; k < ACTIVE; k++) begin
      int v;
      int p = LEAD + k;
      v = (k == 0 || k == ACTIVE - 1) ? int'(ld[p])
          : mid3(int'(ld[p-1]), int'(ld[p]), int'(ld[p+1]));
      if (lo[p]) exp_b++;
      else if (v > mx) ;
      else if (v > thr) exp_b++;
      else exp_d++;
    end
  endfunction

  // effective photosites get eff; all others are over-range full scale
  function automatic void fill_flat(int eff);
    for (int i = 0; i < LINE_LEN; i++) begin
      if (i >= LEAD && i < LEAD + ACTIVE) begin ld[i] = 14'(eff); lo[i] = 1'b0; end
      else begin ld[i] = 14'h3fff; lo[i] = 1'b1; end
    end
  endfunction

  task automatic drive_line(int thr, int mx, int gap_pct, bit thr_flip, bit bogus, int n);
    @(negedge clk);
    line_start_i = 1'b1; thresh_i = 14'(thr); ceil_i = 14'(mx);
    pix_valid_i = bogus; pix_data_i = 14'h3fff; pix_ovf_i = 1'b1;
    @(negedge clk);
    line_start_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      while ($urandom_range(0, 99) < gap_pct) begin
        pix_valid_i = 1'b0; pix_data_i = 14'($urandom); pix_ovf_i = 1'b1;
        @(negedge clk);
      end
      pix_valid_i = 1'b1; pix_data_i = ld[i]; pix_ovf_i = lo[i];
      if (thr_flip && i == 100) begin thresh_i = ~14'(thr); ceil_i = 14'(thr); end
      @(negedge clk);
    end
    if (n == LINE_LEN) begin
      for (int j = 0; j < 12; j++) begin   // idle clocks past the line end
        pix_valid_i = 1'b1; pix_data_i = 14'h3fff; pix_ovf_i = 1'b1;
        @(negedge clk);
      end
    end
    pix_valid_i = 1'b0; pix_ovf_i = 1'b0;
  endtask

  task automatic run_line(string req, int thr, int mx, int gap_pct, bit thr_flip, bit bogus);
    int p0;
    p0 = pulses;
    model(thr, mx);
    drive_line(thr, mx, gap_pct, thr_flip, bogus, LINE_LEN);
    repeat (10) @(negedge clk);
    chk({req, " bright"}, cap_b, exp_b);
    chk({req, " dark"}, cap_d, exp_d);
    chk("R7 one strobe per line", pulses - p0, 1);
    chk("R7 counts held", int'(bright_cnt_o), exp_b);
  endtask

  initial begin
    void'($urandom(32'h5eed_0ccd));
    repeat (3) @(negedge clk);
    chk("R6 reset bright", int'(bright_cnt_o), 0);
    chk("R6 reset dark", int'(dark_cnt_o), 0);
    chk("R7 reset strobe", int'(result_valid_o), 0);
    rst_ni = 1'b1;
    // R1: stray pixels before the first line start
    repeat (20) begin
      @(negedge clk); pix_valid_i = 1'b1; pix_data_i = 14'h3fff; pix_ovf_i = 1'b1;
    end
    @(negedge clk); pix_valid_i = 1'b0;
    chk("R1 no count before line start", int'(bright_cnt_o), 0);

    fill_flat(10);   run_line("R1 window", 50, 16000, 0, 0, 0);
    fill_flat(300);  run_line("R2 equal is dark", 300, 16000, 0, 0, 0);
    fill_flat(301);  run_line("R2 above is bright", 300, 16000, 0, 0, 0);

    // R3: spikes, isolated interior (removed), ends and pairs (kept)
    fill_flat(10);
    ld[LEAD] = 14'd1000; ld[LEAD+ACTIVE-1] = 14'd1000;
    ld[LEAD+500] = 14'd1000; ld[LEAD+2000] = 14'd1000;
    ld[LEAD+3000] = 14'd1000; ld[LEAD+3001] = 14'd1000;
    ld[LEAD+4000] = 14'd0;
    model(500, 16000);
    chk("R3 model sanity", exp_b, 4);
    run_line("R3 median", 500, 16000, 0, 0, 0);

    // R4: isolated overflow with zero data, one beside a ceiling-rejected value
    fill_flat(10);
    lo[LEAD+100] = 1'b1; ld[LEAD+100] = 14'd0;
    lo[LEAD+1] = 1'b1; ld[LEAD+1] = 14'h3fff;
    lo[LEAD+ACTIVE-1] = 1'b1; ld[LEAD+ACTIVE-1] = 14'h3fff;
    run_line("R4 overflow", 500, 600, 0, 0, 0);

    // R5: a run of values above the ceiling
    fill_flat(10);
    for (int k = 1000; k < 1300; k++) ld[LEAD+k] = 14'd9000;
    for (int k = 2000; k < 2100; k++) ld[LEAD+k] = 14'd700;
    run_line("R5 ceiling", 500, 8000, 0, 0, 0);

    fill_flat(400);  run_line("R8 threshold change ignored", 300, 16000, 0, 1, 0);
    fill_flat(10);   run_line("R9 pixel at line start", 50, 16000, 0, 0, 1);

    // R9: abort a line midway and start over
    begin
      int p0;
      p0 = pulses;
      fill_flat(400);
      drive_line(50, 16000, 0, 0, 0, 3000);
      fill_flat(10);
      run_line("R9 restart", 50, 16000, 5, 0, 0);
      chk("R9 aborted line has no strobe", pulses - p0, 1);
    end

    for (int r = 0; r < 7; r++) begin
      int thr, mx, s0, s1;
      thr = $urandom_range(2000, 14000);
      mx  = thr + $urandom_range(200, 2000);
      s0  = $urandom_range(500, 2000);
      s1  = s0 + $urandom_range(100, 2500);
      for (int i = 0; i < LINE_LEN; i++) begin
        int u, k;
        k = i - LEAD;
        u = $urandom_range(0, 99);
        lo[i] = 1'b0;
        if (k < 0 || k >= ACTIVE) begin
          ld[i] = 14'($urandom); lo[i] = 1'($urandom_range(0, 1));
        end else if (u < 2) ld[i] = (u == 0) ? 14'h3fff : 14'd0;
        else if (u < 4) begin ld[i] = 14'($urandom); lo[i] = 1'b1; end
        else if (k >= s0 && k < s1) ld[i] = 14'(thr - int'($urandom_range(0, 400)));
        else ld[i] = 14'(thr + int'($urandom_range(0, 400)));
      end
      run_line("R2 random line", thr, mx, 10, r[0], 0);
    end
    chk("R7 strobe width", wide, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule